// File: doc/BRIEF.md
# Byte Memory Browse and Edit Controller

This block pairs a small single-port byte memory with a two-mode control state machine driven by three one-cycle pulses: up, down and enter. In browse mode the up and down pulses move a current address through the memory. The address appears in binary on eight LED outputs. The byte stored there appears as two hexadecimal digits on a pair of seven-segment outputs.

An enter pulse switches the block to edit mode. It takes a working copy of the byte at the current address. The same up and down pulses then change that working copy, and the address stays where it is. The displays show the working copy. A second enter pulse commits the working copy to the current address and returns the block to browse mode. The inputs are expected to be debounced single-cycle pulses. Display multiplexing and board wiring are handled elsewhere.

Top module: `mem_browse_edit`

## Requirements
- R1: A synchronous reset puts the block in browse mode at address 0x00 and clears every memory byte to 0x00.
- R2: In browse mode an up pulse adds one to the current address modulo 256, so 0xFF steps to 0x00.
- R3: In browse mode a down pulse subtracts one from the current address modulo 256, so 0x00 steps to 0xFF.
- R4: `addr_leds` shows the current address in binary. Bit 0 is the address LSB.
- R5: Each seven-segment output is active high with bit 0 = segment a through bit 6 = segment g. The hex digits 0 to F are coded 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71. `seg_hi` shows the upper nibble and `seg_lo` shows the lower nibble of the shown byte.
- R6: An enter pulse in browse mode enters edit mode. It loads the working byte from the stored byte at the current address. The address does not change while in edit mode.
- R7: In edit mode, up adds one and down subtracts one from the working byte modulo 256. The displays show the working byte, and the memory is not written.
- R8: An enter pulse in edit mode writes the working byte to the current address only and returns to browse mode. Other addresses keep their contents.
- R9: At most one pulse acts per cycle, with priority enter over up over down. All outputs change in the cycle after the acting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_pulse | input | 1 | One-cycle up request |
| down_pulse | input | 1 | One-cycle down request |
| enter_pulse | input | 1 | One-cycle enter/approve request |
| addr_leds | output | 8 | Current address in binary |
| seg_hi | output | 7 | Seven-segment code of the upper hex digit |
| seg_lo | output | 7 | Seven-segment code of the lower hex digit |

## Verification
Every output follows the registered address, the mode and the working byte through logic with no further registers. A wrong internal value therefore shows on the LEDs or the digits in the very cycle after the edge that caused it. The exception is a wrong memory write while editing. It stays hidden behind the working-byte display until the approving enter pulse, or until the user browses back to the affected address. The bench compares all three outputs after every single pulse. It also revisits neighbouring addresses after each commit.

// File: rtl/membrowse_pkg.sv
package membrowse_pkg;

  typedef enum logic {
    MODE_BROWSE = 1'b0,
    MODE_EDIT   = 1'b1
  } ui_mode_t;

  // active-high segments, bit0 = a ... bit6 = g
  function automatic logic [6:0] hex_to_seg(input logic [3:0] nib);
    logic [6:0] s;
    case (nib)
      4'h0: s = 7'h3F;
      4'h1: s = 7'h06;
      4'h2: s = 7'h5B;
      4'h3: s = 7'h4F;
      4'h4: s = 7'h66;
      4'h5: s = 7'h6D;
      4'h6: s = 7'h7D;
      4'h7: s = 7'h07;
      4'h8: s = 7'h7F;
      4'h9: s = 7'h6F;
      4'hA: s = 7'h77;
      4'hB: s = 7'h7C;
      4'hC: s = 7'h39;
      4'hD: s = 7'h5E;
      4'hE: s = 7'h79;
      default: s = 7'h71;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/byte_store.sv
module byte_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      mem_q[addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[addr];

  // R8
  store_readback_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (addr != $past(addr)) || (rd_data == $past(wr_data)));

endmodule

// File: rtl/hex_digit_seg.sv
module hex_digit_seg (
  input  logic [3:0] nibble,
  output logic [6:0] seg
);
  import membrowse_pkg::*;

  assign seg = hex_to_seg(nibble);

endmodule

// File: rtl/ui_ctrl.sv
module ui_ctrl #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up,
  input  logic          down,
  input  logic          enter,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] shown,
  output logic          wr_en,
  output logic [DW-1:0] wr_data
);
  import membrowse_pkg::*;

  ui_mode_t      mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] pend_q;

  // decoded single action per cycle: enter > up > down
  logic act_enter, act_up, act_down;
  assign act_enter = enter;
  assign act_up    = up & ~enter;
  assign act_down  = down & ~up & ~enter;

  logic in_edit;
  assign in_edit = (mode_q == MODE_EDIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_BROWSE;
      addr_q <= '0;
      pend_q <= '0;
    end else if (act_enter) begin
      mode_q <= in_edit ? MODE_BROWSE : MODE_EDIT;
      if (!in_edit) pend_q <= rd_data;
    end else if (in_edit) begin
      if (act_up)        pend_q <= pend_q + 1'b1;
      else if (act_down) pend_q <= pend_q - 1'b1;
    end else begin
      if (act_up)        addr_q <= addr_q + 1'b1;
      else if (act_down) addr_q <= addr_q - 1'b1;
    end
  end

  assign addr    = addr_q;
  assign shown   = in_edit ? pend_q : rd_data;
  assign wr_en   = in_edit & act_enter;
  assign wr_data = pend_q;

  // R6
  addr_frozen_in_edit_chk: assert property (@(posedge clk) disable iff (rst)
    in_edit |=> $stable(addr_q));

  // R2
  addr_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_edit && up && !enter) |=> addr_q == AW'($past(addr_q) + 1));

  // R3
  addr_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_edit && down && !up && !enter) |=> addr_q == AW'($past(addr_q) - 1));

  // R9
  enter_wins_chk: assert property (@(posedge clk) disable iff (rst)
    enter |=> mode_q != $past(mode_q));

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (in_edit && !enter && !up && !down) |=> $stable(pend_q));

endmodule

// File: rtl/mem_browse_edit.sv
module mem_browse_edit #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          up_pulse,
  input  logic          down_pulse,
  input  logic          enter_pulse,
  output logic [AW-1:0] addr_leds,
  output logic [6:0]    seg_hi,
  output logic [6:0]    seg_lo
);
  localparam int NDIG = DW / 4;

  logic [AW-1:0] cur_addr;
  logic [DW-1:0] rd_data, shown, wr_data;
  logic          wr_en;
  logic [6:0]    digit_seg [NDIG];

  ui_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst),
    .up(up_pulse), .down(down_pulse), .enter(enter_pulse),
    .rd_data(rd_data), .addr(cur_addr), .shown(shown),
    .wr_en(wr_en), .wr_data(wr_data)
  );

  byte_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(cur_addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    hex_digit_seg u_seg (.nibble(shown[4*g +: 4]), .seg(digit_seg[g]));
  end

  assign addr_leds = cur_addr;
  assign seg_lo    = digit_seg[0];
  assign seg_hi    = digit_seg[NDIG-1];

endmodule

// File: tb/mem_browse_edit_bench.sv
module mem_browse_edit_bench;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [7:0] addr;
    logic [6:0] hi;
    logic [6:0] lo;
    string      tag;
  } exp_t;

  localparam logic [6:0] SEG_TAB [16] = '{
    7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07,
    7'h7F, 7'h6F, 7'h77, 7'h7C, 7'h39, 7'h5E, 7'h79, 7'h71};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up_pulse = 1'b0, down_pulse = 1'b0, enter_pulse = 1'b0;
  logic [7:0] addr_leds;
  logic [6:0] seg_hi, seg_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  exp_t exp_q [$];

  // reference model
  logic [7:0] m_mem [256];
  logic [7:0] m_addr = 8'h00;
  logic [7:0] m_pend = 8'h00;
  bit         m_edit = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_browse_edit u_mem_browse_edit (
    .clk(clk), .rst(rst),
    .up_pulse(up_pulse), .down_pulse(down_pulse), .enter_pulse(enter_pulse),
    .addr_leds(addr_leds), .seg_hi(seg_hi), .seg_lo(seg_lo)
  );

  // driver: apply one cycle of inputs, advance the model, queue the expectation
  task automatic step(input bit u, input bit d, input bit e, input string tag);
    exp_t x;
    logic [7:0] show;
    @(negedge clk);
    up_pulse = u; down_pulse = d; enter_pulse = e;
    if (e) begin
      if (m_edit) m_mem[m_addr] = m_pend;
      else        m_pend = m_mem[m_addr];
      m_edit = !m_edit;
    end else if (u) begin
      if (m_edit) m_pend = m_pend + 8'd1; else m_addr = m_addr + 8'd1;
    end else if (d) begin
      if (m_edit) m_pend = m_pend - 8'd1; else m_addr = m_addr - 8'd1;
    end
    show = m_edit ? m_pend : m_mem[m_addr];
    x.addr = m_addr;
    x.hi   = SEG_TAB[show[7:4]];
    x.lo   = SEG_TAB[show[3:0]];
    x.tag  = tag;
    exp_q.push_back(x);
  endtask

  // monitor: compare after each edge has settled
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      exp_t x;
      x = exp_q.pop_front();
      checks++;
      if (addr_leds !== x.addr || seg_hi !== x.hi || seg_lo !== x.lo) begin
        errors++;
        $display("FAIL %s: addr=%h hi=%h lo=%h expected addr=%h hi=%h lo=%h",
                 x.tag, addr_leds, seg_hi, seg_lo, x.addr, x.hi, x.lo);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    step(0, 0, 0, "R1");
    // R2 / R4 address up
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R2");
    // R3 address down through zero
    for (int i = 0; i < 5; i++) step(0, 1, 0, "R3");
    // R2 wrap FF -> 00
    step(1, 0, 0, "R2"); step(1, 0, 0, "R2");
    // R3 wrap 00 -> FF
    step(0, 0, 0, "R4"); step(1, 0, 0, "R2"); step(0, 1, 0, "R3");
    step(0, 1, 0, "R3");
    // R6 enter edit at FF
    step(0, 0, 1, "R6");
    // R7 data steps, including wrap below zero
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R7");
    for (int i = 0; i < 5; i++) step(0, 1, 0, "R7");
    // R9 up beats down
    step(1, 1, 0, "R9");
    step(0, 0, 0, "R7");
    // R8 approve
    step(0, 0, 1, "R8");
    step(1, 0, 0, "R8");
    step(0, 1, 0, "R8");
    step(0, 1, 0, "R8");
    step(1, 0, 0, "R8");
    // R9 enter beats up in browse
    step(1, 0, 1, "R9");
    // R5 / R7 sweep every digit code
    for (int i = 0; i < 256; i++) step(1, 0, 0, "R5");
    step(0, 1, 0, "R7");
    // R9 enter beats down in edit
    step(0, 1, 1, "R9");
    step(1, 0, 0, "R8");
    step(0, 1, 0, "R8");
    // R6 re-enter edit loads stored byte
    step(0, 0, 1, "R6");
    step(0, 0, 1, "R8");
    step(0, 0, 0, "R1");
    @(negedge clk);
    up_pulse = 0; down_pulse = 0; enter_pulse = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule